// File: doc/BRIEF.md
# Code Order Watchdog

This block is a clocked state machine. On every rising clock edge it samples a small input code and checks whether the codes arrive in a fixed order. An all-zero code arms the check. After that, the first code value and the second code value must alternate. If any other value arrives while the check is armed, the machine moves into a fault state. It stays there for exactly one clock and then drops back to idle, where it waits to be armed again.

The state is held in a register. A status word is decoded from the registered state by combinational logic only, so the status changes only after a rising clock edge and never follows the input directly. The reset is active-low and synchronous. It places the machine straight into the state that expects the first code, so a freshly reset system must present the first code at once. The input code must already be synchronous to the clock.

Top module: `seqmon_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next status is 0001 (expecting the first code), whatever the value of `code_in`.
- R2: In idle (status 0000), a `code_in` of 0000 at an edge moves the status to 0001. Any other code leaves the status at 0000.
- R3: While expecting the first code (status 0001), a `code_in` of 0001 moves the status to 0010. Any other code moves it to 1111 (fault).
- R4: While expecting the second code (status 0010), a `code_in` of 0010 moves the status back to 0001. Any other code moves it to 1111.
- R5: In fault (status 1111), the next edge always moves the status to 0000, whatever the value of `code_in`, including 0000.
- R6: The status depends only on the registered state. A change of `code_in` between two clock edges leaves `status` unchanged until the next rising edge.
- R7: Once reset has been applied, `status` only ever takes one of the four values 0000, 0001, 0010 or 1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state changes happen on the rising edge. |
| rst_n | input | 1 | Active-low synchronous reset. Forces the machine into the state that expects the first code. |
| code_in | input | CODE_W (4) | Input code, sampled every rising edge. |
| status | output | CODE_W (4) | Decoded state: 0000 idle, 0001 expecting the first code, 0010 expecting the second code, 1111 fault. |

## Verification
The properties take `code_in` and `rst_n` as values that are settled at each rising edge, with no metastable or glitching bits. This is because they predict the next status from the status and code seen at the current edge. The bench keeps to this by changing every input on the falling edge only, half a period away from the sampling edge. It reads `status` one nanosecond after each rising edge. Each property is switched off while reset is low, except the reset property itself. The bench asserts reset before the first edge, so no property ever sees the unknown state that exists at power-up.

// File: rtl/seqmon_pkg.sv
package seqmon_pkg;

    // Symbolic states of the order checker.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WANT_A = 2'd1,
        ST_WANT_B = 2'd2,
        ST_FAULT  = 2'd3
    } seq_state_t;

    // Registered content of the block.
    typedef struct packed {
        seq_state_t state;
    } seq_regs_t;

endpackage

// File: rtl/seqmon_next.sv
module seqmon_next
    import seqmon_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter logic [CODE_W-1:0] ARM_CODE    = '0,
    parameter logic [CODE_W-1:0] FIRST_CODE  = CODE_W'(1),
    parameter logic [CODE_W-1:0] SECOND_CODE = CODE_W'(2)
) (
    input  seq_state_t        cur_state,
    input  logic [CODE_W-1:0] code,
    output seq_state_t        nxt_state
);

    logic hit_arm;
    logic hit_first;
    logic hit_second;

    always_comb begin
        hit_arm    = (code == ARM_CODE);
        hit_first  = (code == FIRST_CODE);
        hit_second = (code == SECOND_CODE);
    end

    always_comb begin
        nxt_state = ST_IDLE;
        unique case (cur_state)
            ST_IDLE:   nxt_state = hit_arm    ? ST_WANT_A : ST_IDLE;
            ST_WANT_A: nxt_state = hit_first  ? ST_WANT_B : ST_FAULT;
            ST_WANT_B: nxt_state = hit_second ? ST_WANT_A : ST_FAULT;
            ST_FAULT:  nxt_state = ST_IDLE;
            default:   nxt_state = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/seqmon_decode.sv
module seqmon_decode
    import seqmon_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter logic [CODE_W-1:0] FIRST_CODE  = CODE_W'(1),
    parameter logic [CODE_W-1:0] SECOND_CODE = CODE_W'(2)
) (
    input  seq_state_t        cur_state,
    output logic [CODE_W-1:0] status
);

    localparam logic [CODE_W-1:0] IDLE_WORD  = '0;
    localparam logic [CODE_W-1:0] FAULT_WORD = '1;

    always_comb begin
        status = IDLE_WORD;
        unique case (cur_state)
            ST_IDLE:   status = IDLE_WORD;
            ST_WANT_A: status = FIRST_CODE;
            ST_WANT_B: status = SECOND_CODE;
            ST_FAULT:  status = FAULT_WORD;
            default:   status = IDLE_WORD;
        endcase
    end

endmodule

// File: rtl/seqmon_top.sv
module seqmon_top
    import seqmon_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] status
);

    localparam logic [CODE_W-1:0] ARM_C    = '0;
    localparam logic [CODE_W-1:0] FIRST_C  = CODE_W'(1);
    localparam logic [CODE_W-1:0] SECOND_C = CODE_W'(2);

    seq_regs_t  regs_d;
    seq_regs_t  regs_q;
    seq_state_t step_state;

    seqmon_next #(
        .CODE_W      (CODE_W),
        .ARM_CODE    (ARM_C),
        .FIRST_CODE  (FIRST_C),
        .SECOND_CODE (SECOND_C)
    ) u_next (
        .cur_state (regs_q.state),
        .code      (code_in),
        .nxt_state (step_state)
    );

    always_comb begin
        regs_d = regs_q;
        if (!rst_n) begin
            regs_d.state = ST_WANT_A;
        end else begin
            regs_d.state = step_state;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    seqmon_decode #(
        .CODE_W      (CODE_W),
        .FIRST_CODE  (FIRST_C),
        .SECOND_CODE (SECOND_C)
    ) u_decode (
        .cur_state (regs_q.state),
        .status    (status)
    );

endmodule

// File: rtl/seqmon_chk.sv
module seqmon_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] code_in,
    input logic [CODE_W-1:0] status
);

    localparam logic [CODE_W-1:0] S_IDLE  = '0;
    localparam logic [CODE_W-1:0] S_A     = CODE_W'(1);
    localparam logic [CODE_W-1:0] S_B     = CODE_W'(2);
    localparam logic [CODE_W-1:0] S_FAULT = '1;

    // R1
    reset_entry_chk: assert property (@(posedge clk)
        !rst_n |=> status == S_A);

    // R2
    idle_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == S_IDLE && code_in == S_IDLE) |=> status == S_A);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == S_IDLE && code_in != S_IDLE) |=> status == S_IDLE);

    // R3
    first_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == S_A && code_in == S_A) |=> status == S_B);

    // R3
    first_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == S_A && code_in != S_A) |=> status == S_FAULT);

    // R4
    second_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == S_B && code_in == S_B) |=> status == S_A);

    // R4
    second_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == S_B && code_in != S_B) |=> status == S_FAULT);

    // R5
    fault_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status == S_FAULT |=> status == S_IDLE);

    // R7
    legal_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (status == S_IDLE || status == S_A ||
                          status == S_B || status == S_FAULT));

endmodule

bind seqmon_top seqmon_chk #(.CODE_W(CODE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_in (code_in),
    .status  (status)
);

// File: tb/sim_seqmon_top.sv
`timescale 1ns/1ps
module sim_seqmon_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] code_in = 4'h0;
    logic [3:0] status;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    seqmon_top #(.CODE_W(4)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_in (code_in),
        .status  (status)
    );

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: status=%b expected=%b", req, got, exp);
        end
        // R7: every observed word after reset is legal
        if (!(got === 4'h0 || got === 4'h1 || got === 4'h2 || got === 4'hF)) begin
            n_bad++;
            $display("FAIL R7: status=%b expected one of 0000/0001/0010/1111", got);
        end
    endtask

    // Drive on the falling edge, sample 1 ns after the next rising edge.
    task automatic step(input logic rst_v, input logic [3:0] c, input string req,
                        input logic [3:0] exp);
        @(negedge clk);
        rst_n   = rst_v;
        code_in = c;
        @(posedge clk);
        #1;
        check(req, status, exp);
    endtask

    task automatic t_reset;
        step(1'b0, 4'hA, "R1 reset entry", 4'h1);
        step(1'b1, 4'h1, "R3 after reset", 4'h2);
        step(1'b0, 4'h7, "R1 reset from second", 4'h1);
    endtask

    task automatic t_main_sequence;
        step(1'b1, 4'h7, "R3 leave to fault", 4'hF);
        step(1'b1, 4'h3, "R5 fault to idle", 4'h0);
        step(1'b1, 4'h0, "R2 arm", 4'h1);
        step(1'b1, 4'h1, "R3 first code", 4'h2);
        step(1'b1, 4'h2, "R4 second code", 4'h1);
        step(1'b1, 4'h1, "R3 first again", 4'h2);
        step(1'b1, 4'h7, "R4 bad code to fault", 4'hF);
        step(1'b1, 4'h7, "R5 fault recovers", 4'h0);
    endtask

    task automatic t_idle_hold;
        step(1'b1, 4'h5, "R2 idle holds 0101", 4'h0);
        step(1'b1, 4'hF, "R2 idle holds 1111", 4'h0);
        step(1'b1, 4'h1, "R2 idle holds 0001", 4'h0);
    endtask

    task automatic t_first_bad;
        step(1'b1, 4'h0, "R2 arm", 4'h1);
        step(1'b1, 4'h2, "R3 wrong order to fault", 4'hF);
    endtask

    task automatic t_fault_ignores_arm;
        step(1'b1, 4'h0, "R5 fault ignores 0000", 4'h0);
        step(1'b1, 4'h0, "R2 arm after fault", 4'h1);
    endtask

    task automatic t_second_bad;
        step(1'b1, 4'h1, "R3 first code", 4'h2);
        step(1'b1, 4'h0, "R4 zero in second", 4'hF);
        step(1'b1, 4'h2, "R5 fault ignores 0010", 4'h0);
    endtask

    task automatic t_moore;
        step(1'b1, 4'h0, "R2 arm", 4'h1);
        @(negedge clk);
        code_in = 4'h9;
        #1;
        check("R6 no change before edge (bad code)", status, 4'h1);
        code_in = 4'h1;
        #1;
        check("R6 no change before edge (good code)", status, 4'h1);
        @(posedge clk);
        #1;
        check("R6 change after edge", status, 4'h2);
    endtask

    initial begin
        t_reset();
        t_main_sequence();
        t_idle_hold();
        t_first_bad();
        t_fault_ignores_arm();
        t_second_bad();
        t_moore();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule